// File: doc/BRIEF.md
# NAND Command Front-End Responder

This block models the device side of the command front end of an 8-bit NAND flash. A host drives a shared byte bus together with chip-enable, command-latch and address-latch qualifiers. The block captures a byte on each low-to-high transition of the write strobe. The command-latch input marks the byte as a command and the address-latch input marks it as an address. All strobes are sampled in the block's own clock domain. While chip-enable is high, the block ignores every strobe.

Two operations are decoded. The first is identification: the command byte 90h followed by the address byte 00h starts an identification sequence. Each later read strobe then returns the next of five fixed bytes. The sequence stays active until a new command arrives. The second is reset: the command byte FFh aborts whatever array operation is busy, through a one-cycle abort pulse to a stub array. It holds ready/busy low for a parameterised number of clock cycles and reloads the status register. The stub array reports its own activity on a busy input, and the block folds that input into ready/busy.

The controller has four named states. IDLE waits for a command. ID_ADDR has seen 90h and waits for the address. ID_READ serves identification bytes. RESET counts out the reset time. The transitions are as follows:
- IDLE to ID_ADDR on 90h.
- ID_ADDR to ID_READ on address 00h.
- ID_ADDR to IDLE on any other address.
- ID_READ or ID_ADDR to ID_ADDR on a fresh 90h, or to IDLE on any other command.
- Any state to RESET on FFh.
- RESET to IDLE when the count expires.

Top module: `nand_cmd_front`

## Requirements
- R1: With ce_n low, a byte is captured when we_n goes from 0 to 1. It counts as a command when cle=1 and ale=0, and as an address when ale=1 and cle=0. Command 90h followed by address 00h enters identification mode.
- R2: In identification mode, while re_n=0 and ce_n=0, io_oe=1 and io_out carries the current byte. The byte index advances when re_n returns to 1. The bytes come in the order ECh, DAh, 10h, 95h, 44h.
- R3: After the five identification bytes have been read, each further read in identification mode returns 00h with io_oe=1.
- R4: Identification mode persists across reads until a command is written. Any command other than 90h or FFh returns to IDLE. A new 90h plus 00h restarts the sequence at ECh.
- R5: status is 00h after power-on reset. Latching FFh sets status to C0h when wp_n=1 and to 40h when wp_n=0; wp_n is sampled at the latch.
- R6: rb_n is 0 for exactly RST_CYCLES clock cycles, starting in the cycle after FFh is latched, and then returns to 1.
- R7: An FFh latched during reset restarts the full RST_CYCLES count. Any other command or address during reset is ignored.
- R8: Latching FFh raises array_abort for exactly one cycle, the cycle after the latch. rb_n is 0 whenever array_busy is 1.
- R9: An address byte that does not follow 90h is ignored. An address other than 00h after 90h returns to IDLE. Read strobes outside identification mode keep io_oe=0 and io_out=00h.
- R10: While ce_n is 1, write and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command-latch qualifier |
| ale | input | 1 | Address-latch qualifier |
| we_n | input | 1 | Write strobe, byte captured on rising transition |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write-protect, active low |
| io_in | input | 8 | Byte bus from host |
| io_out | output | 8 | Byte bus to host |
| io_oe | output | 1 | Bus drive enable (0 = high impedance) |
| array_busy | input | 1 | Busy indication from stub array operation |
| array_abort | output | 1 | One-cycle abort request to stub array |
| rb_n | output | 1 | Ready/busy, 0 = busy |
| status | output | 8 | Status register value |

## Verification
The hardest situation to reach is a second FFh that lands while a reset count is still running. It has to arrive late enough that a count which failed to restart would be visibly short, yet early enough that rb_n is still low. The bench issues a reset, waits four cycles, issues another, and then measures the low time of rb_n from the second latch. While that reset runs, it also writes 90h and, after the reset, an address of 00h. This shows that the command written during the reset was dropped.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ID_ADDR = 2'd1,
        ST_ID_READ = 2'd2,
        ST_RESET   = 2'd3
    } fsm_t;

    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] ADDR_IDENT = 8'h00;
    localparam logic [6:0] STAT_LOW   = 7'h40;
    localparam int         ID_LEN     = 5;

    function automatic logic [7:0] ident_byte(input int unsigned pos);
        case (pos)
            0:       ident_byte = 8'hEC;
            1:       ident_byte = 8'hDA;
            2:       ident_byte = 8'h10;
            3:       ident_byte = 8'h95;
            4:       ident_byte = 8'h44;
            default: ident_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic re_n,
    output logic we_rise,
    output logic re_rise
);
    logic we_q;
    logic re_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_rise = !ce_n && !we_q && we_n;
    assign re_rise = !ce_n && !re_q && re_n;
endmodule

// File: rtl/nand_id_table.sv
module nand_id_table #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       id_byte
);
    import nand_cmd_pkg::*;

    always_comb begin
        id_byte = ident_byte(32'(idx));
    end
endmodule

// File: rtl/nand_rst_timer.sv
module nand_rst_timer #(
    parameter int RST_CYCLES = 64,
    localparam int CW = $clog2(RST_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(RST_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
    parameter int RST_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    input  logic       array_busy,
    output logic       array_abort,
    output logic       rb_n,
    output logic [7:0] status
);
    import nand_cmd_pkg::*;

    localparam int IDX_W = $clog2(ID_LEN + 1);
    localparam int CW    = $clog2(RST_CYCLES + 1);

    fsm_t             state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       status_q;
    logic             abort_q;
    logic             we_rise, re_rise;
    logic             cmd_stb, adr_stb, rst_hit;
    logic [CW-1:0]    rst_cnt;
    logic             rst_last;
    logic [7:0]       id_b;

    nand_strobe_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .re_n    (re_n),
        .we_rise (we_rise),
        .re_rise (re_rise)
    );

    assign cmd_stb = we_rise && cle && !ale;
    assign adr_stb = we_rise && ale && !cle;
    assign rst_hit = cmd_stb && (io_in == CMD_RESET);

    nand_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rst_hit),
        .cnt   (rst_cnt),
        .last  (rst_last)
    );

    nand_id_table #(.IDX_W(IDX_W)) u_table (
        .idx     (idx_q),
        .id_byte (id_b)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (rst_hit) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_ID_READ: begin
                    if (cmd_stb)
                        state_d = (io_in == CMD_IDENT) ? ST_ID_ADDR : ST_IDLE;
                end
                ST_ID_ADDR: begin
                    if (cmd_stb)
                        state_d = (io_in == CMD_IDENT) ? ST_ID_ADDR : ST_IDLE;
                    else if (adr_stb)
                        state_d = (io_in == ADDR_IDENT) ? ST_ID_READ : ST_IDLE;
                end
                ST_RESET: begin
                    if (rst_last)
                        state_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            status_q <= 8'h00;
            abort_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            abort_q <= rst_hit;
            if (rst_hit)
                status_q <= {wp_n, STAT_LOW};
            if (state_d == ST_ID_READ && state_q != ST_ID_READ)
                idx_q <= '0;
            else if (state_q == ST_ID_READ && re_rise && idx_q != IDX_W'(ID_LEN))
                idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        io_oe       = (state_q == ST_ID_READ) && !re_n && !ce_n;
        io_out      = io_oe ? id_b : 8'h00;
        rb_n        = (state_q != ST_RESET) && !array_busy;
        array_abort = abort_q;
        status      = status_q;
    end
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk #(
    parameter int RST_CYCLES = 64,
    localparam int CW = $clog2(RST_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          re_n,
    input logic          io_oe,
    input logic          rb_n,
    input logic          array_abort,
    input logic [7:0]    status,
    input logic [CW-1:0] rst_cnt
);
    // R2
    oe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> (!re_n && !ce_n));

    // R8
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        array_abort |=> !array_abort);

    // R8
    abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        array_abort |-> !rb_n);

    // R5
    status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> (status == 8'hC0 || status == 8'h40));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cnt <= CW'(RST_CYCLES));

    // R6
    busy_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_cnt != '0) |-> !rb_n);
endmodule

bind nand_cmd_front nand_cmd_front_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .re_n        (re_n),
    .io_oe       (io_oe),
    .rb_n        (rb_n),
    .array_abort (array_abort),
    .status      (status),
    .rst_cnt     (rst_cnt)
);

// File: tb/tb_nand_cmd_front.sv
`timescale 1ns/1ps
module tb_nand_cmd_front;
    localparam int NRST = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic       wp_n = 1'b1, array_busy = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out, status;
    logic       io_oe, array_abort, rb_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nand_cmd_front #(.RST_CYCLES(NRST)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .array_busy(array_busy),
        .array_abort(array_abort), .rb_n(rb_n), .status(status)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    byte unsigned ident[$] = '{8'hEC, 8'hDA, 8'h10, 8'h95, 8'h44};
    string m_mode = "idle";
    int  m_left = 0, m_pos = 0;
    int  m_stat = 0;
    bit  m_abort = 0;
    bit  p_we = 1, p_re = 1;

    always @(posedge clk) begin
        if (rst_n) begin
            bit wr, rd;
            wr = !ce_n && !p_we && we_n;
            rd = !ce_n && !p_re && re_n;
            m_abort = 0;
            if (m_mode == "reset") begin
                m_left--;
                if (m_left == 0) m_mode = "idle";
            end
            if (m_mode == "id" && rd) m_pos++;
            if (wr && cle && !ale) begin
                if (io_in == 8'hFF) begin
                    m_mode = "reset"; m_left = NRST; m_abort = 1;
                    m_stat = wp_n ? 8'hC0 : 8'h40;
                end else if (m_mode != "reset") begin
                    m_mode = (io_in == 8'h90) ? "wait" : "idle";
                end
            end else if (wr && ale && !cle && m_mode == "wait") begin
                if (io_in == 8'h00) begin m_mode = "id"; m_pos = 0; end
                else m_mode = "idle";
            end
            p_we = we_n;
            p_re = re_n;
            #1;
            begin
                bit e_oe;
                int e_out;
                e_oe  = (m_mode == "id") && !re_n && !ce_n;
                e_out = e_oe ? (m_pos < ident.size() ? int'(ident[m_pos]) : 0) : 0;
                chk("R2", "model io_oe", io_oe, e_oe);
                chk("R3", "model io_out", io_out, e_out);
                chk("R6", "model rb_n", rb_n, (m_mode != "reset") && !array_busy);
                chk("R5", "model status", status, m_stat);
                chk("R8", "model array_abort", array_abort, m_abort);
            end
        end
    end

    task automatic wr_byte(input bit is_cmd, input logic [7:0] b, input bit ce = 1'b0);
        @(negedge clk);
        ce_n = ce; cle = is_cmd; ale = !is_cmd; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic rd_byte(input string req, input bit exp_oe, input int exp_b, input bit ce = 1'b0);
        @(negedge clk);
        ce_n = ce; re_n = 1'b0;
        @(negedge clk);
        chk(req, "read io_oe", io_oe, exp_oe);
        chk(req, "read io_out", io_out, exp_b);
        re_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
    endtask

    task automatic busy_len(input string req, input int exp);
        int n = 0;
        while (!rb_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(req, "rb_n low cycles", n, exp);
    endtask

    bit done = 0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R5 power-on
        chk("R5", "power-on status", status, 8'h00);
        chk("R6", "power-on rb_n", rb_n, 1);
        chk("R9", "power-on io_oe", io_oe, 0);

        // R9: stray address, then read outside ID mode
        wr_byte(0, 8'h00);
        rd_byte("R9", 0, 8'h00);

        // R1 R2: identification sequence
        wr_byte(1, 8'h90);
        wr_byte(0, 8'h00);
        for (int i = 0; i < 5; i++) rd_byte("R2", 1, ident[i]);
        // R3: beyond end
        rd_byte("R3", 1, 8'h00);
        rd_byte("R3", 1, 8'h00);

        // R4: other command leaves ID mode; new ID restarts
        wr_byte(1, 8'h30);
        rd_byte("R4", 0, 8'h00);
        wr_byte(1, 8'h90);
        wr_byte(0, 8'h00);
        rd_byte("R4", 1, 8'hEC);
        rd_byte("R4", 1, 8'hDA);

        // R10: ce_n high blocks strobes
        rd_byte("R10", 0, 8'h00, 1'b1);
        wr_byte(1, 8'hFF, 1'b1);
        chk("R10", "rb_n after masked reset", rb_n, 1);
        chk("R10", "status after masked reset", status, 8'h00);
        rd_byte("R10", 1, 8'h10);

        // R9: non-zero address after 90h
        wr_byte(1, 8'h90);
        wr_byte(0, 8'h01);
        rd_byte("R9", 0, 8'h00);

        // R5 R6: reset with wp_n high
        wp_n = 1'b1;
        wr_byte(1, 8'hFF);
        chk("R5", "status wp high", status, 8'hC0);
        busy_len("R6", NRST);

        // R7: repeated reset restarts; other command ignored
        wr_byte(1, 8'hFF);
        repeat (4) @(negedge clk);
        wr_byte(1, 8'hFF);
        busy_len("R7", NRST);
        wr_byte(1, 8'hFF);
        wr_byte(1, 8'h90);
        busy_len("R7", NRST - 3);
        wr_byte(0, 8'h00);
        rd_byte("R7", 0, 8'h00);

        // R8: busy hook and abort pulse
        array_busy = 1'b1;
        @(negedge clk);
        chk("R8", "rb_n with array busy", rb_n, 0);
        @(negedge clk);
        ce_n = 1'b0; cle = 1'b1; io_in = 8'hFF; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        chk("R8", "abort pulse", array_abort, 1);
        cle = 1'b0;
        array_busy = 1'b0;
        @(negedge clk);
        chk("R8", "abort ends", array_abort, 0);
        busy_len("R6", NRST - 1);

        // R5: reset with wp_n low
        wp_n = 1'b0;
        wr_byte(1, 8'hFF);
        chk("R5", "status wp low", status, 8'h40);
        busy_len("R6", NRST);
        wp_n = 1'b1;

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule